// File: doc/BRIEF.md
# Cache Block Instruction Decode and Enable Check

This block sits in the decode stage of a processor pipeline and recognises the cache-block instructions: the three management operations (invalidate, clean, flush), the block-zero operation and the three prefetch hints (read, write, instruction). For each instruction word it reports the operation to perform. It applies the privilege-dependent enable fields held in the machine, supervisor and hypervisor control registers, and decides whether the instruction traps. When it traps, the block reports whether the trap is an illegal-instruction trap or a virtual-instruction trap. An invalidate may also be turned quietly into a flush.

Alongside the decision the block produces two values. One is a normalised copy of the instruction word that a trap handler can record. The other is the address offset for prefetches. Address translation and the memory access itself belong to later stages. A parameter chooses whether the result is registered (one cycle of latency) or passed straight through.

Top module: `cbo_decode_stage`

## Requirements
- R1: An accepted word with bits [6:0]=0x0F, bits [14:12]=2 and bits [11:7]=0 is a block operation, selected by bits [31:20]: 0x000 gives op 1 (invalidate), 0x001 gives op 2 (clean), 0x002 gives op 3 (flush) and 0x004 gives op 4 (zero). When the operation does not trap, it is reported with that op code, except for an invalidate that R6 converts.
- R2: A word with bits [6:0]=0x13, bits [14:12]=6 and bits [11:7]=0 is a prefetch when bits [24:20] are 0 (op 7, instruction), 1 (op 5, read) or 3 (op 6, write). Its offset output is bits [31:25] sign-extended to ADDR_W bits, with bits [4:0] of the offset zero.
- R3: Any other word, including the two forms above with a different selector or a nonzero bits [11:7], gives op 0 with both trap flags low and with the trap-info and offset outputs zero.
- R4: Privilege codes are U=0, S=1, M=3, VU=4 and VS=5. An instruction is disabled at a level when that level's field is 00 (invalidate, 2-bit field) or 0 (clean and flush share one bit; zero has its own bit). A block operation raises the illegal-instruction flag when the mode is not M and the machine level disables it, or when the mode is U and the supervisor level disables it.
- R5: A block operation that does not trap as illegal raises the virtual-instruction flag when the mode is VS and the hypervisor level disables it, or when the mode is VU and either the hypervisor or the supervisor level disables it. The two flags are never both high.
- R6: A non-trapping invalidate is reported as flush (op 3) when any field that applies to the current mode equals 01. The machine field applies outside M. The supervisor field applies in U and VU. The hypervisor field applies in VS and VU. Otherwise the invalidate is reported as op 1, which includes the reserved value 10.
- R7: In M mode no block operation traps and an invalidate is reported as op 1, whatever the enable fields hold.
- R8: Prefetches never raise either trap flag, in any mode and under any enable setting.
- R9: For a block operation, trap info equals the instruction word with bits [19:15] and [11:7] cleared. For any other word it is zero.
- R10: With REG_OUT=1, the results for a word accepted with in_valid high appear with out_valid high on the next clock. A cycle with in_valid low yields out_valid low and all other outputs zero. Reset clears every output.
- R11: A trapping block operation keeps its decoded op code, so a trapping invalidate reports op 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| priv | input | 3 | Current privilege mode (U=0, S=1, M=3, VU=4, VS=5) |
| m_inval_ctl | input | 2 | Machine-level invalidate control |
| s_inval_ctl | input | 2 | Supervisor-level invalidate control |
| h_inval_ctl | input | 2 | Hypervisor-level invalidate control |
| m_cleanflush_en | input | 1 | Machine-level clean/flush enable |
| s_cleanflush_en | input | 1 | Supervisor-level clean/flush enable |
| h_cleanflush_en | input | 1 | Hypervisor-level clean/flush enable |
| m_zero_en | input | 1 | Machine-level zero enable |
| s_zero_en | input | 1 | Supervisor-level zero enable |
| h_zero_en | input | 1 | Hypervisor-level zero enable |
| out_valid | output | 1 | Result is present |
| out_op | output | 3 | Operation code (0 none, 1..7 as in R1/R2) |
| out_illegal | output | 1 | Illegal-instruction trap |
| out_virtual | output | 1 | Virtual-instruction trap |
| out_trap_info | output | 32 | Normalised instruction for trap reporting |
| out_pf_offset | output | ADDR_W | Prefetch address offset |

## Verification
The hardest case to reach is the interaction of the three invalidate control levels in the virtualised modes. In VU mode a 00 at one level must give a trap while a 01 at another level decides between flush and invalidate. The reserved 10 must act as plain enable. To cover this, the stimulus sweeps all 64 combinations of the three 2-bit invalidate fields under each of the five privilege modes, with the unrelated enable bits driven to a pattern that changes with each combination so that cross-talk would show. The single-bit clean/flush and zero enables get the same exhaustive sweep, followed by prefetches with positive and negative offsets under fully disabled controls and near-miss encodings that must fall through as op 0.

// File: rtl/cbo_dec_pkg.sv
package cbo_dec_pkg;

   localparam int ILEN = 32;

   localparam logic [6:0]  OPC_MISC_MEM = 7'h0F;
   localparam logic [6:0]  OPC_OP_IMM   = 7'h13;
   localparam logic [2:0]  F3_BLOCK     = 3'd2;
   localparam logic [2:0]  F3_ORI       = 3'd6;

   localparam logic [11:0] SEL_INVAL = 12'h000;
   localparam logic [11:0] SEL_CLEAN = 12'h001;
   localparam logic [11:0] SEL_FLUSH = 12'h002;
   localparam logic [11:0] SEL_ZERO  = 12'h004;

   localparam logic [4:0]  PF_SEL_INSTR = 5'd0;
   localparam logic [4:0]  PF_SEL_READ  = 5'd1;
   localparam logic [4:0]  PF_SEL_WRITE = 5'd3;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_INVAL = 3'd1,
      OP_CLEAN = 3'd2,
      OP_FLUSH = 3'd3,
      OP_ZERO  = 3'd4,
      OP_PF_RD = 3'd5,
      OP_PF_WR = 3'd6,
      OP_PF_IN = 3'd7
   } cbo_op_e;

   typedef enum logic [2:0] {
      MODE_U  = 3'd0,
      MODE_S  = 3'd1,
      MODE_M  = 3'd3,
      MODE_VU = 3'd4,
      MODE_VS = 3'd5
   } priv_e;

   localparam int NUM_CLS   = 3;
   localparam int CLS_INVAL = 0;
   localparam int CLS_CLNFL = 1;
   localparam int CLS_ZERO  = 2;

   localparam logic [1:0] CTL_TRAP  = 2'b00;
   localparam logic [1:0] CTL_FLUSH = 2'b01;

endpackage

// File: rtl/cbo_field_decode.sv
module cbo_field_decode
   import cbo_dec_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ILEN-1:0]   instr,
   output logic              is_block,
   output cbo_op_e           raw_op,
   output logic [1:0]        cls,
   output logic [ILEN-1:0]   trap_info,
   output logic [ADDR_W-1:0] pf_offset
);
   localparam int EXT_W = ADDR_W - 12;

   logic [6:0]  opc;
   logic [2:0]  f3;
   logic [4:0]  rd;
   logic [11:0] sel12;
   logic [4:0]  sel5;
   logic        blk_form;
   logic        pf_form;
   logic        is_pf;

   assign opc   = instr[6:0];
   assign rd    = instr[11:7];
   assign f3    = instr[14:12];
   assign sel12 = instr[31:20];
   assign sel5  = instr[24:20];

   assign blk_form = (opc == OPC_MISC_MEM) && (f3 == F3_BLOCK) && (rd == 5'd0);
   assign pf_form  = (opc == OPC_OP_IMM)   && (f3 == F3_ORI)   && (rd == 5'd0);

   always_comb begin
      raw_op   = OP_NONE;
      cls      = 2'(CLS_INVAL);
      is_block = 1'b0;
      is_pf    = 1'b0;
      if (blk_form) begin
         unique case (sel12)
            SEL_INVAL: begin raw_op = OP_INVAL; cls = 2'(CLS_INVAL); is_block = 1'b1; end
            SEL_CLEAN: begin raw_op = OP_CLEAN; cls = 2'(CLS_CLNFL); is_block = 1'b1; end
            SEL_FLUSH: begin raw_op = OP_FLUSH; cls = 2'(CLS_CLNFL); is_block = 1'b1; end
            SEL_ZERO:  begin raw_op = OP_ZERO;  cls = 2'(CLS_ZERO);  is_block = 1'b1; end
            default:   ;
         endcase
      end else if (pf_form) begin
         unique case (sel5)
            PF_SEL_INSTR: begin raw_op = OP_PF_IN; is_pf = 1'b1; end
            PF_SEL_READ:  begin raw_op = OP_PF_RD; is_pf = 1'b1; end
            PF_SEL_WRITE: begin raw_op = OP_PF_WR; is_pf = 1'b1; end
            default:      ;
         endcase
      end
   end

   assign trap_info = is_block ? {instr[31:20], 5'd0, instr[14:12], 5'd0, instr[6:0]}
                               : '0;
   assign pf_offset = is_pf ? {{EXT_W{instr[31]}}, instr[31:25], 5'd0} : '0;

endmodule

// File: rtl/cbo_enable_check.sv
module cbo_enable_check
   import cbo_dec_pkg::*;
(
   input  logic [2:0] priv,
   input  logic       m_en,
   input  logic       s_en,
   input  logic       h_en,
   output logic       illegal,
   output logic       virt
);
   logic not_m, is_u, is_vs, is_vu;

   assign not_m = (priv != MODE_M);
   assign is_u  = (priv == MODE_U);
   assign is_vs = (priv == MODE_VS);
   assign is_vu = (priv == MODE_VU);

   assign illegal = (not_m && !m_en) || (is_u && !s_en);
   assign virt    = !illegal &&
                    ((is_vs && !h_en) || (is_vu && !(h_en && s_en)));

endmodule

// File: rtl/cbo_inval_resolve.sv
module cbo_inval_resolve
   import cbo_dec_pkg::*;
(
   input  logic [2:0] priv,
   input  logic [1:0] m_ctl,
   input  logic [1:0] s_ctl,
   input  logic [1:0] h_ctl,
   output logic       as_flush
);
   logic m_fl, s_fl, h_fl;

   assign m_fl = (m_ctl == CTL_FLUSH);
   assign s_fl = (s_ctl == CTL_FLUSH);
   assign h_fl = (h_ctl == CTL_FLUSH);

   always_comb begin
      unique case (priv)
         MODE_M:  as_flush = 1'b0;
         MODE_S:  as_flush = m_fl;
         MODE_U:  as_flush = m_fl || s_fl;
         MODE_VS: as_flush = m_fl || h_fl;
         MODE_VU: as_flush = m_fl || h_fl || s_fl;
         default: as_flush = m_fl;
      endcase
   end

endmodule

// File: rtl/cbo_out_stage.sv
module cbo_out_stage #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  logic [WIDTH-1:0] d,
   output logic             q_valid,
   output logic [WIDTH-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
         end else begin
            q_valid <= d_valid;
            q       <= d;
         end
      end
   end else begin : g_comb
      assign q_valid = d_valid;
      assign q       = d;
   end

endmodule

// File: rtl/cbo_decode_stage.sv
module cbo_decode_stage
   import cbo_dec_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [2:0]        priv,
   input  logic [1:0]        m_inval_ctl,
   input  logic [1:0]        s_inval_ctl,
   input  logic [1:0]        h_inval_ctl,
   input  logic              m_cleanflush_en,
   input  logic              s_cleanflush_en,
   input  logic              h_cleanflush_en,
   input  logic              m_zero_en,
   input  logic              s_zero_en,
   input  logic              h_zero_en,
   output logic              out_valid,
   output logic [2:0]        out_op,
   output logic              out_illegal,
   output logic              out_virtual,
   output logic [31:0]       out_trap_info,
   output logic [ADDR_W-1:0] out_pf_offset
);
   localparam int PACK_W = 3 + 1 + 1 + ILEN + ADDR_W;

   if (ADDR_W < 12 || ADDR_W > 128) begin : g_bad_addr_w
      $error("cbo_decode_stage: ADDR_W must lie in 12..128");
   end

   logic              is_block;
   cbo_op_e           raw_op;
   logic [1:0]        cls;
   logic [ILEN-1:0]   info_c;
   logic [ADDR_W-1:0] off_c;

   cbo_field_decode #(.ADDR_W(ADDR_W)) u_fields (
      .instr     (instr),
      .is_block  (is_block),
      .raw_op    (raw_op),
      .cls       (cls),
      .trap_info (info_c),
      .pf_offset (off_c)
   );

   logic [NUM_CLS-1:0] en_m, en_s, en_h, ill_v, virt_v;

   assign en_m[CLS_INVAL] = (m_inval_ctl != CTL_TRAP);
   assign en_s[CLS_INVAL] = (s_inval_ctl != CTL_TRAP);
   assign en_h[CLS_INVAL] = (h_inval_ctl != CTL_TRAP);
   assign en_m[CLS_CLNFL] = m_cleanflush_en;
   assign en_s[CLS_CLNFL] = s_cleanflush_en;
   assign en_h[CLS_CLNFL] = h_cleanflush_en;
   assign en_m[CLS_ZERO]  = m_zero_en;
   assign en_s[CLS_ZERO]  = s_zero_en;
   assign en_h[CLS_ZERO]  = h_zero_en;

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      cbo_enable_check u_check (
         .priv    (priv),
         .m_en    (en_m[c]),
         .s_en    (en_s[c]),
         .h_en    (en_h[c]),
         .illegal (ill_v[c]),
         .virt    (virt_v[c])
      );
   end

   logic inval_as_flush;

   cbo_inval_resolve u_resolve (
      .priv     (priv),
      .m_ctl    (m_inval_ctl),
      .s_ctl    (s_inval_ctl),
      .h_ctl    (h_inval_ctl),
      .as_flush (inval_as_flush)
   );

   logic    ill_sel, virt_sel;
   logic    ill_c, virt_c;
   cbo_op_e op_c;

   always_comb begin
      unique case (cls)
         2'(CLS_CLNFL): begin ill_sel = ill_v[CLS_CLNFL]; virt_sel = virt_v[CLS_CLNFL]; end
         2'(CLS_ZERO):  begin ill_sel = ill_v[CLS_ZERO];  virt_sel = virt_v[CLS_ZERO];  end
         default:       begin ill_sel = ill_v[CLS_INVAL]; virt_sel = virt_v[CLS_INVAL]; end
      endcase
   end

   always_comb begin
      ill_c  = in_valid && is_block && ill_sel;
      virt_c = in_valid && is_block && virt_sel;
      op_c   = in_valid ? raw_op : OP_NONE;
      if (op_c == OP_INVAL && !ill_c && !virt_c && inval_as_flush)
         op_c = OP_FLUSH;
   end

   logic [PACK_W-1:0] pack_d, pack_q;

   assign pack_d = in_valid ? {op_c, ill_c, virt_c, info_c, off_c} : '0;

   cbo_out_stage #(.WIDTH(PACK_W), .REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d       (pack_d),
      .q_valid (out_valid),
      .q       (pack_q)
   );

   assign {out_op, out_illegal, out_virtual, out_trap_info, out_pf_offset} = pack_q;

endmodule

module cbo_decode_chk #(
   parameter int ADDR_W  = 64,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        priv,
   input logic              out_valid,
   input logic [2:0]        out_op,
   input logic              out_illegal,
   input logic              out_virtual,
   input logic [31:0]       out_trap_info,
   input logic [ADDR_W-1:0] out_pf_offset
);
   logic op_is_pf, op_is_blk;
   assign op_is_pf  = (out_op >= 3'd5);
   assign op_is_blk = (out_op >= 3'd1) && (out_op <= 3'd4);

   // R5: the two trap kinds exclude each other
   p_traps_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_illegal && out_virtual));

   // R8: prefetches never trap
   p_prefetch_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_is_pf |-> (!out_illegal && !out_virtual));

   // R10: idle slot is quiet
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_op == 3'd0 && !out_illegal && !out_virtual &&
                      out_trap_info == '0 && out_pf_offset == '0));

   // R2: prefetch offset is block aligned, and zero for non-prefetch
   p_offset_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_pf_offset[4:0] == 5'd0) && (op_is_pf || out_pf_offset == '0));

   // R11: only block operations carry a trap
   p_trap_only_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_illegal || out_virtual) |-> op_is_blk);

   // R9: register fields cleared; info only for block operations
   p_info_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_trap_info[19:15] == 5'd0) && (out_trap_info[11:7] == 5'd0) &&
      (op_is_blk || out_trap_info == '0));

   if (REG_OUT) begin : g_reg_props
      // R7: machine mode never traps
      p_machine_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(in_valid && priv == 3'd3) |-> (!out_illegal && !out_virtual));

      // R10: result follows an accepted word by one cycle
      p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(in_valid) |-> out_valid);
   end

endmodule

bind cbo_decode_stage cbo_decode_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .priv          (priv),
   .out_valid     (out_valid),
   .out_op        (out_op),
   .out_illegal   (out_illegal),
   .out_virtual   (out_virtual),
   .out_trap_info (out_trap_info),
   .out_pf_offset (out_pf_offset)
);

// File: tb/cbo_decode_stage_tb.sv
module cbo_decode_stage_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          in_valid = 1'b0;
   logic [31:0]   instr = '0;
   logic [2:0]    priv = '0;
   logic [1:0]    mi = '0, si = '0, hi = '0;
   logic          mc = 1'b0, sc = 1'b0, hc = 1'b0;
   logic          mz = 1'b0, sz = 1'b0, hz = 1'b0;
   logic          out_valid;
   logic [2:0]    out_op;
   logic          out_illegal, out_virtual;
   logic [31:0]   out_trap_info;
   logic [AW-1:0] out_pf_offset;

   cbo_decode_stage #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .priv(priv),
      .m_inval_ctl(mi), .s_inval_ctl(si), .h_inval_ctl(hi),
      .m_cleanflush_en(mc), .s_cleanflush_en(sc), .h_cleanflush_en(hc),
      .m_zero_en(mz), .s_zero_en(sz), .h_zero_en(hz),
      .out_valid(out_valid), .out_op(out_op), .out_illegal(out_illegal),
      .out_virtual(out_virtual), .out_trap_info(out_trap_info),
      .out_pf_offset(out_pf_offset)
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic          e_vld;
   logic [2:0]    e_op;
   logic          e_ill, e_virt;
   logic [31:0]   e_info;
   logic [AW-1:0] e_off;

   // Reference model written from the requirements
   task automatic model(input logic v);
      logic [6:0] opc;
      logic [2:0] f3;
      logic [4:0] rd, sel5;
      logic [11:0] sel12;
      logic em, es, eh, fl;
      int klass;
      e_vld = v; e_op = 0; e_ill = 0; e_virt = 0; e_info = 0; e_off = 0;
      if (!v) return;
      opc = instr[6:0]; rd = instr[11:7]; f3 = instr[14:12];
      sel12 = instr[31:20]; sel5 = instr[24:20];
      klass = -1;
      if (opc == 7'h0F && f3 == 3'd2 && rd == 0) begin
         if (sel12 == 12'h000) begin e_op = 1; klass = 0; end
         else if (sel12 == 12'h001) begin e_op = 2; klass = 1; end
         else if (sel12 == 12'h002) begin e_op = 3; klass = 1; end
         else if (sel12 == 12'h004) begin e_op = 4; klass = 2; end
      end else if (opc == 7'h13 && f3 == 3'd6 && rd == 0) begin
         if (sel5 == 0) e_op = 7;
         else if (sel5 == 1) e_op = 5;
         else if (sel5 == 3) e_op = 6;
         if (e_op != 0) begin
            e_off = AW'(signed'({instr[31:25], 5'b0}));
         end
      end
      if (klass >= 0) begin
         e_info = instr & 32'hFFF0_707F;
         if (klass == 0) begin em = (mi != 0); es = (si != 0); eh = (hi != 0); end
         else if (klass == 1) begin em = mc; es = sc; eh = hc; end
         else begin em = mz; es = sz; eh = hz; end
         if (priv != 3) begin
            if (!em) e_ill = 1;
            else if (priv == 0 && !es) e_ill = 1;
            else if (priv == 5 && !eh) e_virt = 1;
            else if (priv == 4 && (!eh || !es)) e_virt = 1;
         end
         if (klass == 0 && !e_ill && !e_virt && priv != 3) begin
            fl = (mi == 2'b01);
            if ((priv == 0 || priv == 4) && si == 2'b01) fl = 1;
            if ((priv == 5 || priv == 4) && hi == 2'b01) fl = 1;
            if (fl) e_op = 3;
         end
      end
   endtask

   task automatic compare(input string tag);
      n_checks++;
      if (out_valid !== e_vld || out_op !== e_op || out_illegal !== e_ill ||
          out_virtual !== e_virt || out_trap_info !== e_info || out_pf_offset !== e_off) begin
         n_fail++;
         $display("FAIL %s: got vld=%b op=%0d ill=%b virt=%b info=%h off=%h exp vld=%b op=%0d ill=%b virt=%b info=%h off=%h",
                  tag, out_valid, out_op, out_illegal, out_virtual, out_trap_info, out_pf_offset,
                  e_vld, e_op, e_ill, e_virt, e_info, e_off);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, compare.
   task automatic step(input logic v, input logic [31:0] w, input logic [2:0] p,
                       input logic [11:0] ctl, input string tag);
      in_valid = v; instr = w; priv = p;
      {mi, si, hi, mc, sc, hc, mz, sz, hz} = ctl;
      model(v);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic [31:0] blk(input logic [11:0] s, input logic [4:0] rs1);
      return {s, rs1, 3'd2, 5'd0, 7'h0F};
   endfunction

   function automatic logic [31:0] pf(input logic [6:0] hi7, input logic [4:0] kind,
                                      input logic [4:0] rs1);
      return {hi7, kind, rs1, 3'd6, 5'd0, 7'h13};
   endfunction

   string tg;

   initial begin
      repeat (2000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] modes [5];
      logic [11:0] blk_sel [4];
      modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd3; modes[3] = 3'd4; modes[4] = 3'd5;
      blk_sel[0] = 12'h000; blk_sel[1] = 12'h001; blk_sel[2] = 12'h002; blk_sel[3] = 12'h004;

      // R10: reset state
      repeat (2) @(negedge clk);
      in_valid = 1'b1; instr = blk(12'h001, 5'd3);
      model(1'b0);
      compare("R10 reset");
      rst_n = 1'b1;
      in_valid = 1'b0;

      // R7 / R1: machine mode, all enables off
      for (int k = 0; k < 4; k++)
         step(1, blk(blk_sel[k], 5'd7), 3'd3, 12'h000, "R7 R1 machine");

      // R9: register fields cleared in trap info
      step(1, blk(12'h002, 5'd31), 3'd0, 12'hFFF, "R9 info");

      // R2 / R8: prefetches under disabled controls, both offset signs
      step(1, pf(7'h05, 5'd1, 5'd2), 3'd0, 12'h000, "R2 R8 pf read");
      step(1, pf(7'h7F, 5'd3, 5'd9), 3'd4, 12'h000, "R2 R8 pf write neg");
      step(1, pf(7'h40, 5'd0, 5'd1), 3'd5, 12'h000, "R2 R8 pf instr min");
      step(1, pf(7'h3F, 5'd1, 5'd1), 3'd1, 12'h000, "R2 R8 pf max");

      // R10: idle cycles between work
      step(0, blk(12'h000, 5'd1), 3'd0, 12'h000, "R10 idle");
      step(0, pf(7'h11, 5'd1, 5'd1), 3'd0, 12'hFFF, "R10 idle");

      // R3: near misses
      step(1, pf(7'h01, 5'd2, 5'd1), 3'd0, 12'hFFF, "R3 ori sel2");
      step(1, pf(7'h01, 5'd4, 5'd1), 3'd0, 12'hFFF, "R3 ori sel4");
      step(1, blk(12'h003, 5'd1), 3'd0, 12'h000, "R3 blk sel3");
      step(1, blk(12'h001, 5'd1) | 32'h0000_0080, 3'd0, 12'h000, "R3 rd nonzero");
      step(1, {12'h001, 5'd1, 3'd1, 5'd0, 7'h0F}, 3'd0, 12'h000, "R3 f3");
      step(1, 32'h0020_8033, 3'd0, 12'h000, "R3 other");

      // R4 R5 R6 R11: invalidate sweep over all three 2-bit fields
      for (int p = 0; p < 5; p++) begin
         for (int k = 0; k < 64; k++) begin
            logic [11:0] ctl;
            ctl = {k[5:0], ~k[5:0]};
            in_valid = 1'b1; instr = blk(12'h000, 5'd4); priv = modes[p];
            {mi, si, hi, mc, sc, hc, mz, sz, hz} = ctl;
            model(1'b1);
            if (e_ill) tg = "R4 R11 inval";
            else if (e_virt) tg = "R5 R11 inval";
            else tg = "R6 inval";
            step(1, blk(12'h000, 5'd4), modes[p], ctl, tg);
         end
      end

      // R4 R5 R1: clean, flush and zero sweeps over single-bit enables
      for (int p = 0; p < 5; p++) begin
         for (int s = 1; s < 4; s++) begin
            for (int k = 0; k < 8; k++) begin
               logic [11:0] ctl;
               ctl = {k[1:0], k[2:1], k[0], k[2], 3'(k), 3'(k)};
               in_valid = 1'b1; instr = blk(blk_sel[s], 5'd6); priv = modes[p];
               {mi, si, hi, mc, sc, hc, mz, sz, hz} = ctl;
               model(1'b1);
               if (e_ill) tg = "R4 blk";
               else if (e_virt) tg = "R5 blk";
               else tg = "R1 blk";
               step(1, blk(blk_sel[s], 5'd6), modes[p], ctl, tg);
            end
         end
      end

      // R8: prefetch sweep over every mode with controls all off
      for (int p = 0; p < 5; p++)
         step(1, pf(7'(p * 19), 5'd3, 5'd5), modes[p], 12'h000, "R8 pf modes");

      step(0, 32'h0, 3'd0, 12'h000, "R10 final idle");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule